// File: doc/BRIEF.md
# I/O Register Bit-Set/Clear Unit

This block is one eight-bit I/O register of a small microcontroller-style core. It mixes ordinary read/write storage bits with status flags. Hardware raises a flag with a pulse, and software lowers it by writing a one to it. Software reaches the register in three ways. It can read the whole byte, write the whole byte, or set or clear one bit chosen by a three-bit index. Instruction decode and register addressing sit outside the block, which sees only an operation code.

A static mode input selects how the single-bit operations behave. In legacy mode a bit operation reads the whole byte, changes the addressed bit and writes the whole byte back. Any flag that reads as one is therefore written back as one, which clears it. In modern mode a bit operation touches only the addressed bit, so it is safe on a register that holds flags. A parameter mask picks which bits are flags. Every operation takes one clock cycle.

Top module: `iobit_reg`

## Requirements
- R1: A synchronous active-high reset sets the register to 0x00. Reset takes priority over any operation in the same cycle.
- R2: `op` = 2'b01 is a byte write, and it behaves the same in both modes. Each plain bit takes the value of `wr_data`. Each flag bit is cleared where `wr_data` holds a one and is kept where it holds a zero.
- R3: `rd_data` always shows the whole stored byte. With `op` = 2'b00 (idle, or a byte read) and no flag pulse, the value does not change.
- R4: A one on `flag_set` sets the matching flag bit in the next cycle. This pulse wins over a clearing write in the same cycle, so the flag stays set.
- R5: `flag_set` has no effect on plain bits.
- R6: With `legacy_mode` = 0, `op` = 2'b10 (bit set) at index `bit_idx` acts on that bit only. Bit 0 is the least significant bit. A plain bit becomes one. A set flag bit is cleared. All other bits are kept.
- R7: With `legacy_mode` = 0, `op` = 2'b11 (bit clear) acts on the addressed bit only. A plain bit becomes zero. A flag bit is unaffected. All other bits are kept.
- R8: With `legacy_mode` = 1, bit set writes the whole byte back with the addressed bit forced to one. The addressed plain bit is set and the other plain bits are kept. Every flag bit ends up zero.
- R9: With `legacy_mode` = 1, bit clear writes the whole byte back with the addressed bit forced to zero. The addressed plain bit is cleared. Every set flag is cleared except the addressed one, which keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | 1: bit operations write the whole byte back; 0: they act on one bit |
| op | input | 2 | 00 idle/read, 01 byte write, 10 bit set, 11 bit clear |
| bit_idx | input | 3 | Index of the addressed bit, 0 = LSB |
| wr_data | input | 8 | Byte write data |
| flag_set | input | 8 | Hardware flag-set pulses, one per bit |
| rd_data | output | 8 | Stored register value |

## Verification
The bench builds the block with the default flag mask 0xF0. That gives four write-one-to-clear flags in the upper nibble and four plain bits in the lower nibble. Every operation therefore reaches both kinds of bit at once. The contrast between the modes shows in one byte: a legacy bit operation visibly clears unrelated flags while also changing a plain bit. The same mask lets the bench collide flag pulses with clearing writes and bit operations, and drive pulses on plain bits that must be ignored.

// File: rtl/iobit_pkg.sv
package iobit_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned IDX_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_BSET  = 2'b10,
        OP_BCLR  = 2'b11
    } iob_op_e;

    // Write request presented to the storage cells: value and per-bit enable.
    typedef struct packed {
        logic [DATA_W-1:0] val;
        logic [DATA_W-1:0] en;
    } iob_wr_t;

    function automatic logic [DATA_W-1:0] all_ones();
        return {DATA_W{1'b1}};
    endfunction

endpackage

// File: rtl/iobit_bitsel.sv
module iobit_bitsel
    import iobit_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] onehot
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_sel
        assign onehot[i] = (idx == IDX_W'(i));
    end
endmodule

// File: rtl/iobit_wrform.sv
module iobit_wrform
    import iobit_pkg::*;
(
    input  logic              legacy,
    input  iob_op_e           op,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] onehot,
    output iob_wr_t           wr
);
    always_comb begin
        wr.val = '0;
        wr.en  = '0;
        unique case (op)
            OP_WRITE: begin
                wr.val = wdata;
                wr.en  = all_ones();
            end
            OP_BSET: begin
                if (legacy) begin
                    // whole byte goes back, read ones included
                    wr.val = cur | onehot;
                    wr.en  = all_ones();
                end else begin
                    wr.val = onehot;
                    wr.en  = onehot;
                end
            end
            OP_BCLR: begin
                if (legacy) begin
                    wr.val = cur & ~onehot;
                    wr.en  = all_ones();
                end else begin
                    wr.val = '0;
                    wr.en  = onehot;
                end
            end
            default: begin
                wr.val = '0;
                wr.en  = '0;
            end
        endcase
    end
endmodule

// File: rtl/iobit_cell.sv
module iobit_cell #(
    parameter bit IS_FLAG = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_val,
    input  logic hw_set,
    output logic q
);
    logic q_nxt;

    if (IS_FLAG) begin : g_flag
        // write-one clears; a hardware pulse overrides the clear
        always_comb q_nxt = hw_set | (q & ~(wr_en & wr_val));
    end else begin : g_plain
        always_comb q_nxt = wr_en ? wr_val : q;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= q_nxt;
    end
endmodule

// File: rtl/iobit_reg.sv
module iobit_reg
    import iobit_pkg::*;
#(
    parameter logic [7:0] FLAG_MASK = 8'hF0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       legacy_mode,
    input  logic [1:0] op,
    input  logic [2:0] bit_idx,
    input  logic [7:0] wr_data,
    input  logic [7:0] flag_set,
    output logic [7:0] rd_data
);
    logic [DATA_W-1:0] onehot;
    logic [DATA_W-1:0] cur;
    iob_wr_t           wr;

    iobit_bitsel u_sel (
        .idx    (bit_idx),
        .onehot (onehot)
    );

    iobit_wrform u_form (
        .legacy (legacy_mode),
        .op     (iob_op_e'(op)),
        .wdata  (wr_data),
        .cur    (cur),
        .onehot (onehot),
        .wr     (wr)
    );

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        iobit_cell #(.IS_FLAG(FLAG_MASK[i])) u_cell (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr.en[i]),
            .wr_val (wr.val[i]),
            .hw_set (flag_set[i]),
            .q      (cur[i])
        );
    end

    assign rd_data = cur;
endmodule

// File: rtl/iobit_reg_chk.sv
module iobit_reg_chk #(
    parameter logic [7:0] FLAG_MASK = 8'hF0
) (
    input logic       clk,
    input logic       rst,
    input logic       legacy_mode,
    input logic [1:0] op,
    input logic [2:0] bit_idx,
    input logic [7:0] wr_data,
    input logic [7:0] flag_set,
    input logic [7:0] rd_data
);
    logic       live;
    logic [7:0] sel;

    always_ff @(posedge clk) live <= !rst;
    assign sel = 8'd1 << bit_idx;

    p_reset_zero_r1: assert property (@(posedge clk) rst |=> rd_data == 8'h00);

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (live && op == 2'b00 && flag_set == 8'h00) |=> $stable(rd_data));

    p_byte_write_r2: assert property (@(posedge clk) disable iff (rst)
        (live && op == 2'b01 && flag_set == 8'h00) |=>
        rd_data == (($past(rd_data) & FLAG_MASK & ~$past(wr_data)) | ($past(wr_data) & ~FLAG_MASK)));

    p_flag_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (live && (flag_set & FLAG_MASK) != 8'h00) |=>
        (rd_data & $past(flag_set & FLAG_MASK)) == $past(flag_set & FLAG_MASK));

    p_plain_ignores_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (live && op == 2'b00) |=> (rd_data & ~FLAG_MASK) == ($past(rd_data) & ~FLAG_MASK));

    p_modern_single_bit_r6: assert property (@(posedge clk) disable iff (rst)
        (live && !legacy_mode && op[1] && flag_set == 8'h00) |=>
        (rd_data & ~$past(sel)) == ($past(rd_data) & ~$past(sel)));

    p_modern_clr_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (live && !legacy_mode && op == 2'b11 && (sel & FLAG_MASK) != 8'h00 && flag_set == 8'h00)
        |=> $stable(rd_data));

    p_legacy_set_flags_r8: assert property (@(posedge clk) disable iff (rst)
        (live && legacy_mode && op == 2'b10 && flag_set == 8'h00) |=>
        (rd_data & FLAG_MASK) == 8'h00);

    p_legacy_clr_flags_r9: assert property (@(posedge clk) disable iff (rst)
        (live && legacy_mode && op == 2'b11 && flag_set == 8'h00) |=>
        (rd_data & FLAG_MASK) == ($past(rd_data) & FLAG_MASK & $past(sel)));
endmodule

bind iobit_reg iobit_reg_chk #(.FLAG_MASK(FLAG_MASK)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .legacy_mode (legacy_mode),
    .op          (op),
    .bit_idx     (bit_idx),
    .wr_data     (wr_data),
    .flag_set    (flag_set),
    .rd_data     (rd_data)
);

// File: tb/tb_iobit_reg.sv
`timescale 1ns/1ps
module tb_iobit_reg;
    logic       clk = 1'b0;
    logic       rst;
    logic       legacy_mode;
    logic [1:0] op;
    logic [2:0] bit_idx;
    logic [7:0] wr_data;
    logic [7:0] flag_set;
    logic [7:0] rd_data;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    iobit_reg #(.FLAG_MASK(8'hF0)) dut (
        .clk(clk), .rst(rst), .legacy_mode(legacy_mode), .op(op),
        .bit_idx(bit_idx), .wr_data(wr_data), .flag_set(flag_set), .rd_data(rd_data)
    );

    typedef struct packed {
        logic       mode;
        logic [1:0] op;
        logic [2:0] idx;
        logic [7:0] wd;
        logic [7:0] fs;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    // Flags are bits 7..4, plain bits 3..0. Each row's expect is rd_data after it.
    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'b01, 3'd0, 8'h5A, 8'h00, 8'h0A, 4'd2},  // R2 write, flags clear: none set
        '{1'b0, 2'b00, 3'd0, 8'h00, 8'hF0, 8'hFA, 4'd4},  // R4 raise all flags
        '{1'b0, 2'b00, 3'd0, 8'h00, 8'h0F, 8'hFA, 4'd5},  // R5 pulses on plain bits
        '{1'b0, 2'b00, 3'd0, 8'h00, 8'h00, 8'hFA, 4'd3},  // R3 idle hold
        '{1'b0, 2'b01, 3'd0, 8'h35, 8'h00, 8'hC5, 4'd2},  // R2 clear flags 5,4
        '{1'b0, 2'b10, 3'd1, 8'h00, 8'h00, 8'hC7, 4'd6},  // R6 set plain bit 1
        '{1'b0, 2'b10, 3'd7, 8'h00, 8'h00, 8'h47, 4'd6},  // R6 set on flag 7 clears it only
        '{1'b0, 2'b11, 3'd6, 8'h00, 8'h00, 8'h47, 4'd7},  // R7 clear on flag: no effect
        '{1'b0, 2'b11, 3'd0, 8'h00, 8'h00, 8'h46, 4'd7},  // R7 clear plain bit 0
        '{1'b0, 2'b00, 3'd0, 8'h00, 8'hF0, 8'hF6, 4'd4},  // R4
        '{1'b1, 2'b10, 3'd3, 8'h00, 8'h00, 8'h0E, 4'd8},  // R8 legacy set wipes flags
        '{1'b1, 2'b00, 3'd0, 8'h00, 8'hB0, 8'hBE, 4'd4},  // R4
        '{1'b1, 2'b11, 3'd5, 8'h00, 8'h00, 8'h2E, 4'd9},  // R9 addressed flag survives
        '{1'b1, 2'b00, 3'd0, 8'h00, 8'hD0, 8'hFE, 4'd4},  // R4
        '{1'b1, 2'b11, 3'd2, 8'h00, 8'h00, 8'h0A, 4'd9},  // R9 plain clear wipes flags
        '{1'b1, 2'b00, 3'd0, 8'h00, 8'h10, 8'h1A, 4'd4},  // R4
        '{1'b1, 2'b10, 3'd6, 8'h00, 8'h00, 8'h0A, 4'd8},  // R8 addressed clear flag stays 0
        '{1'b0, 2'b01, 3'd0, 8'hF0, 8'h30, 8'h30, 4'd4},  // R4 pulse beats write clear
        '{1'b0, 2'b10, 3'd4, 8'h00, 8'h10, 8'h30, 4'd4},  // R4 pulse beats bit-set clear
        '{1'b0, 2'b11, 3'd3, 8'h00, 8'h00, 8'h30, 4'd7},  // R7
        '{1'b0, 2'b01, 3'd0, 8'h00, 8'h00, 8'h30, 4'd2},  // R2 zero write holds flags
        '{1'b1, 2'b01, 3'd0, 8'hA5, 8'h00, 8'h15, 4'd2}   // R2 byte write in legacy mode
    };

    task automatic check(input [7:0] exp, input string tag);
        n_vec++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%02h expected=%02h", tag, rd_data, exp);
        end
    endtask

    task automatic drive(input logic m, input logic [1:0] o, input logic [2:0] i,
                         input logic [7:0] w, input logic [7:0] f);
        legacy_mode = m; op = o; bit_idx = i; wr_data = w; flag_set = f;
    endtask

    initial begin
        rst = 1'b1;
        drive(1'b0, 2'b00, 3'd0, 8'h00, 8'h00);
        repeat (3) @(negedge clk);
        check(8'h00, "R1 reset value");
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k].mode, VEC[k].op, VEC[k].idx, VEC[k].wd, VEC[k].fs);
            @(negedge clk);
            check(VEC[k].exp, $sformatf("R%0d vector %0d", VEC[k].req, k));
        end

        // R1: reset beats a simultaneous byte write
        rst = 1'b1;
        drive(1'b0, 2'b01, 3'd0, 8'hFF, 8'hF0);
        @(negedge clk);
        check(8'h00, "R1 reset over write");
        rst = 1'b0;
        drive(1'b0, 2'b00, 3'd0, 8'h00, 8'h00);
        @(negedge clk);
        check(8'h00, "R3 hold after reset");

        // R6: modern set walks every plain bit
        for (int b = 0; b < 4; b++) begin
            drive(1'b0, 2'b10, 3'(b), 8'h00, 8'h00);
            @(negedge clk);
            check(8'((1 << (b + 1)) - 1), "R6 plain bit walk");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule